// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a synthesizable behavioural model of a synchronous burst SRAM whose read path has no output register. The array is word-organised with two 9-bit byte lanes sharing one bidirectional 18-bit data bus. The full-size part holds 65,536 words, which is `ADDR_W = 16`. The default is `ADDR_W = 10` so that elaboration stays small.

A burst begins on a clock edge where one of two active-low address strobes is low. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the global write enable. The captured address supplies the first beat. A 2-bit beat counter then produces the other three beats, in linear or interleaved order, whenever the advance input is low on an edge with no strobe.

Reads are flow-through. The word at the current beat address appears on the bus in the cycle after the edge that selected it. This gives 2-1-1-1 burst timing. Writes are sampled on the clock edge and complete inside the block. The output enable acts on the bus without waiting for a clock. A sleep input freezes all activity and releases the bus, and the stored contents are kept.

Top module: `flowthru_burst_sram`

## Requirements
- R1: After an edge that starts a read burst, the word at the captured address is driven on `data` during the following clock cycle. Each later edge with `advanceN` low presents the next beat's word in the cycle after that edge.
- R2: With `burstMode` = 0 (linear) sampled at the start edge, beat k uses address bits [1:0] = (start bits [1:0] + k) mod 4. The upper address bits stay equal to the captured ones, and beat 4 wraps back to beat 0's address.
- R3: With `burstMode` = 1 (interleaved) sampled at the start edge, beat k uses address bits [1:0] = start bits [1:0] XOR k.
- R4: `procStrobeN` low starts a read burst even when `writeN` and `byteWeN` are low, and no memory word is changed. When both strobes are low on the same edge, the processor strobe wins.
- R5: `ctrlStrobeN` low with `procStrobeN` high starts a write burst if `writeN` is low, and the bus value at that edge is written to the captured address. If `writeN` is high, it starts a read burst.
- R6: On an edge with both strobes high, `advanceN` low steps the burst one beat. In a write burst, the bus value at that edge is then written to the new beat address when `writeN` is low. `advanceN` high holds the current beat address.
- R7: `byteWeN[0]` (active low) enables bits 8:0 and `byteWeN[1]` enables bits 17:9. A lane whose enable is high keeps its stored value during a write.
- R8: `data` is driven only during a read burst with `outEnN` low. Raising `outEnN` releases the bus at once, with no clock edge needed, and the bus is never driven during a write burst.
- R9: While `sleep` is high, strobes, advance and writes are ignored and the bus is released. After `sleep` falls, the held burst resumes and all stored words are unchanged.
- R10: After reset no burst is active and the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rstN | input | 1 | Active-low synchronous reset of the control state |
| addr | input | ADDR_W | Burst start address, captured on a strobe edge |
| procStrobeN | input | 1 | Active-low processor address strobe (always a read) |
| ctrlStrobeN | input | 1 | Active-low controller address strobe (read or write) |
| advanceN | input | 1 | Active-low beat advance |
| writeN | input | 1 | Active-low global write enable |
| byteWeN | input | 2 | Active-low byte-lane write enables |
| burstMode | input | 1 | 0 = linear order, 1 = interleaved order |
| outEnN | input | 1 | Active-low asynchronous output enable |
| sleep | input | 1 | Active-high low-power freeze |
| data | inout | 18 | Shared read/write data bus |

## Verification
Two pairs of functions can land on the same edge. The first pair is the two address strobes: the bench lowers both strobes together with the write enables low. It judges the result by reading back the word at that address and by confirming a later read of a previously written word, which shows that the processor read won and nothing was stored. The second pair is sleep against a pending strobe and advance: the bench asserts sleep during a read burst while presenting a new processor strobe, an advance and a controller write. It then checks that the bus was released, that the old beat word returns when sleep falls, and that the targeted word is unchanged.

// File: rtl/fts_pkg.sv
`timescale 1ns/1ps
package fts_pkg;
  localparam int LANES   = 2;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int BEAT_W  = 2;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic [LANES-1:0] wrLane;    // per-lane write at this edge
    logic             readValid; // a read burst owns the bus
  } ctlStrobes_t;

  // Low address bits for a given beat of a burst.
  function automatic logic [BEAT_W-1:0] beatLow(
    input logic [BEAT_W-1:0] startLow,
    input logic [BEAT_W-1:0] beat,
    input logic              interleaved);
    return interleaved ? (startLow ^ beat) : (startLow + beat);
  endfunction
endpackage

// File: rtl/fts_burst_counter.sv
`timescale 1ns/1ps
module fts_burst_counter
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              step,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              loadMode,
  output logic [ADDR_W-1:0] curAddr,
  output logic [ADDR_W-1:0] nxtAddr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseAddr;
  logic [BEAT_W-1:0] beatCnt;
  logic [BEAT_W-1:0] beatInc;
  logic              modeIl;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
      modeIl   <= 1'b0;
    end else if (load) begin
      baseAddr <= loadAddr;
      beatCnt  <= '0;
      modeIl   <= loadMode;
    end else if (step) begin
      beatCnt  <= beatInc;
    end
  end

  assign beatInc = beatCnt + BEAT_W'(1);
  assign curAddr = {baseAddr[ADDR_W-1 -: HI_W],
                    beatLow(baseAddr[BEAT_W-1:0], beatCnt, modeIl)};

  always_comb begin
    if (load)
      nxtAddr = loadAddr;
    else if (step)
      nxtAddr = {baseAddr[ADDR_W-1 -: HI_W],
                 beatLow(baseAddr[BEAT_W-1:0], beatInc, modeIl)};
    else
      nxtAddr = curAddr;
  end

  // R6: no load and no step keeps the beat address.
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !step) |=> $stable(curAddr));

  // R2: a linear step moves the low bits by one and keeps the upper bits.
  p_step_linear_r2: assert property (@(posedge clk) disable iff (!rstN)
    (step && !load && !modeIl) |=>
      (curAddr[BEAT_W-1:0] == $past(curAddr[BEAT_W-1:0]) + BEAT_W'(1)) &&
      (curAddr[ADDR_W-1 -: HI_W] == $past(curAddr[ADDR_W-1 -: HI_W])));
endmodule

// File: rtl/fts_ctl.sv
`timescale 1ns/1ps
module fts_ctl
  import fts_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             procStrobeN,
  input  logic             ctrlStrobeN,
  input  logic             advanceN,
  input  logic             writeN,
  input  logic [LANES-1:0] byteWeN,
  input  logic             sleep,
  output logic             load,
  output logic             step,
  output ctlStrobes_t      strobes
);
  logic active;
  logic isWrite;
  logic procGo;
  logic ctrlGo;
  logic startWrite;
  logic beatWrite;

  // The processor strobe has priority and always means a read.
  assign procGo     = !procStrobeN && !sleep;
  assign ctrlGo     = !ctrlStrobeN && procStrobeN && !sleep;
  assign load       = procGo || ctrlGo;
  assign startWrite = ctrlGo && !writeN;
  assign step       = !load && !sleep && active && !advanceN;
  assign beatWrite  = step && isWrite && !writeN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      isWrite <= 1'b0;
    end else if (load) begin
      active  <= 1'b1;
      isWrite <= startWrite;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign strobes.wrLane[g] = (startWrite || beatWrite) && !byteWeN[g];
  end
  assign strobes.readValid = active && !isWrite && !sleep;

  // R4: a processor strobe yields a read burst regardless of write enables.
  p_proc_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !sleep) |=> (active && !isWrite));

  // R5: a controller strobe with writeN low yields a write burst.
  p_ctrl_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlStrobeN && procStrobeN && !writeN && !sleep) |=> isWrite);

  // R9: sleep freezes the burst state.
  p_sleep_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> ($stable(active) && $stable(isWrite)));
endmodule

// File: rtl/fts_array.sv
`timescale 1ns/1ps
module fts_array
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              outEnN,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              driveEn
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (strobes.wrLane[g])
        laneMem[wrAddr] <= dataIn[g*LANE_W +: LANE_W];
    end

    // Flow-through: the lane is read combinationally at the beat address.
    assign dataOut[g*LANE_W +: LANE_W] = laneMem[rdAddr];

    // R7: an enabled lane holds the sampled bus value afterwards.
    p_lane_write_r7: assert property (@(posedge clk) disable iff (!rstN)
      strobes.wrLane[g] |=>
        (laneMem[$past(wrAddr)] == $past(dataIn[g*LANE_W +: LANE_W])));
  end

  assign driveEn = strobes.readValid && !outEnN;
endmodule

// File: rtl/flowthru_burst_sram.sv
`timescale 1ns/1ps
module flowthru_burst_sram
  import fts_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              writeN,
  input  logic [LANES-1:0]  byteWeN,
  input  logic              burstMode,
  input  logic              outEnN,
  input  logic              sleep,
  inout  wire  [WORD_W-1:0] data
);
  logic              load;
  logic              step;
  ctlStrobes_t       strobes;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] nxtAddr;
  logic [WORD_W-1:0] dataOut;
  logic              driveEn;

  fts_ctl uCtl (
    .clk(clk), .rstN(rstN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .writeN(writeN), .byteWeN(byteWeN),
    .sleep(sleep), .load(load), .step(step), .strobes(strobes)
  );

  fts_burst_counter #(.ADDR_W(ADDR_W)) uCnt (
    .clk(clk), .rstN(rstN), .load(load), .step(step),
    .loadAddr(addr), .loadMode(burstMode),
    .curAddr(curAddr), .nxtAddr(nxtAddr)
  );

  fts_array #(.ADDR_W(ADDR_W)) uArr (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrAddr(nxtAddr), .rdAddr(curAddr), .outEnN(outEnN),
    .dataIn(data), .dataOut(dataOut), .driveEn(driveEn)
  );

  assign data = driveEn ? dataOut : {WORD_W{1'bz}};
endmodule

// File: tb/flowthru_burst_sram_test.sv
`timescale 1ns/1ps
module flowthru_burst_sram_test;
  localparam int OP_H = 0, OP_W = 1, OP_C = 2, OP_P = 3,
                 OP_R = 4, OP_A = 5, OP_X = 6, OP_PW = 7;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  req;
    logic        mode;
    logic [9:0]  adr;
    logic [17:0] wdata;
    logic [17:0] expd;
    logic        chk;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 4'd5,  1'b0, 10'h041, 18'h000A1, 18'h0, 1'b0}, // R5 write start
    '{3'd2, 4'd6,  1'b0, 10'h000, 18'h000A2, 18'h0, 1'b0}, // R6 write beat -> 042
    '{3'd2, 4'd6,  1'b0, 10'h000, 18'h000A3, 18'h0, 1'b0}, // -> 043
    '{3'd2, 4'd6,  1'b0, 10'h000, 18'h000A4, 18'h0, 1'b0}, // R2 wrap -> 040
    '{3'd3, 4'd1,  1'b0, 10'h042, 18'h0, 18'h000A2, 1'b1}, // R1 first word
    '{3'd5, 4'd2,  1'b0, 10'h000, 18'h0, 18'h000A3, 1'b1}, // R2 linear
    '{3'd5, 4'd2,  1'b0, 10'h000, 18'h0, 18'h000A4, 1'b1},
    '{3'd5, 4'd2,  1'b0, 10'h000, 18'h0, 18'h000A1, 1'b1},
    '{3'd0, 4'd6,  1'b0, 10'h000, 18'h0, 18'h000A1, 1'b1}, // R6 hold
    '{3'd4, 4'd5,  1'b1, 10'h043, 18'h0, 18'h000A3, 1'b1}, // R5 ctrl read
    '{3'd5, 4'd3,  1'b0, 10'h000, 18'h0, 18'h000A2, 1'b1}, // R3 interleaved
    '{3'd5, 4'd3,  1'b0, 10'h000, 18'h0, 18'h000A1, 1'b1},
    '{3'd5, 4'd3,  1'b0, 10'h000, 18'h0, 18'h000A4, 1'b1},
    '{3'd7, 4'd4,  1'b0, 10'h041, 18'h0, 18'h000A1, 1'b1}, // R4 write ignored
    '{3'd5, 4'd4,  1'b0, 10'h000, 18'h0, 18'h000A2, 1'b1},
    '{3'd6, 4'd4,  1'b0, 10'h040, 18'h0, 18'h000A4, 1'b1}, // R4 both strobes
    '{3'd3, 4'd4,  1'b0, 10'h041, 18'h0, 18'h000A1, 1'b1}  // R4 nothing stored
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic [9:0]  addr;
  logic        procStrobeN, ctrlStrobeN, advanceN, writeN;
  logic [1:0]  byteWeN;
  logic        burstMode, outEnN, sleep;
  logic [17:0] tbVal;
  logic        tbDrv;
  wire  [17:0] bus;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  assign bus = tbDrv ? tbVal : 18'bz;

  always #2.5 clk = ~clk;

  flowthru_burst_sram uut (
    .clk(clk), .rstN(rstN), .addr(addr),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .writeN(writeN), .byteWeN(byteWeN),
    .burstMode(burstMode), .outEnN(outEnN), .sleep(sleep), .data(bus)
  );

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, expv);
    end
  endtask

  task automatic idle();
    procStrobeN = 1'b1; ctrlStrobeN = 1'b1; advanceN = 1'b1;
    writeN = 1'b1; byteWeN = 2'b11; outEnN = 1'b0; tbDrv = 1'b0;
  endtask

  // Applies one operation across one rising edge; returns at negedge + 1 ns.
  task automatic cycle(input int op, input logic mode, input logic [9:0] a,
                       input logic [17:0] wd, input logic [1:0] bw);
    idle();
    addr = a; burstMode = mode;
    case (op)
      OP_W:  begin ctrlStrobeN = 0; writeN = 0; byteWeN = bw; outEnN = 1; tbDrv = 1; tbVal = wd; end
      OP_C:  begin advanceN = 0; writeN = 0; byteWeN = bw; outEnN = 1; tbDrv = 1; tbVal = wd; end
      OP_P:  procStrobeN = 0;
      OP_R:  ctrlStrobeN = 0;
      OP_A:  advanceN = 0;
      OP_X:  begin procStrobeN = 0; ctrlStrobeN = 0; writeN = 0; byteWeN = 2'b00; end
      OP_PW: begin procStrobeN = 0; writeN = 0; byteWeN = 2'b00; end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    idle();
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 1'b0; addr = '0; burstMode = 1'b0; sleep = 1'b0; tbVal = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R10: after reset the bus is free; a probe value reads back unchanged.
    tbDrv = 1'b1; tbVal = 18'h2AAAA; #0.5;
    check("R10 bus released after reset", bus, 18'h2AAAA);
    tbDrv = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      cycle(int'(VECS[i].op), VECS[i].mode, VECS[i].adr, VECS[i].wdata, 2'b00);
      if (VECS[i].chk)
        check($sformatf("R%0d vector %0d", VECS[i].req, i), bus, VECS[i].expd);
    end

    // R7: lane 1 disabled keeps upper bits; lane 0 disabled keeps lower bits.
    cycle(OP_W, 0, 10'h100, 18'h3FFFF, 2'b00);
    cycle(OP_W, 0, 10'h100, 18'h00000, 2'b10);
    cycle(OP_W, 0, 10'h104, 18'h3FFFF, 2'b00);
    // R8: during a write burst the bus stays free even with outEnN low.
    tbDrv = 1'b1; tbVal = 18'h0AAAA; #0.5;
    check("R8 no drive in write burst", bus, 18'h0AAAA);
    tbDrv = 1'b0;
    cycle(OP_W, 0, 10'h104, 18'h00000, 2'b01);
    cycle(OP_P, 0, 10'h104, 18'h0, 2'b11);
    check("R7 lane0 held", bus, 18'h001FF);
    cycle(OP_P, 0, 10'h100, 18'h0, 2'b11);
    check("R7 lane1 held", bus, 18'h3FE00);

    // R8: output enable acts without a clock edge.
    outEnN = 1'b1; tbDrv = 1'b1; tbVal = 18'h15555; #0.5;
    check("R8 outEnN high releases", bus, 18'h15555);
    outEnN = 1'b0; tbDrv = 1'b0; #0.5;
    check("R8 outEnN low drives", bus, 18'h3FE00);

    // R9: sleep during a read burst.
    cycle(OP_P, 0, 10'h041, 18'h0, 2'b11);
    check("R9 read before sleep", bus, 18'h000A1);
    sleep = 1'b1; tbDrv = 1'b1; tbVal = 18'h15555; #0.5;
    check("R9 sleep releases bus", bus, 18'h15555);
    tbDrv = 1'b0;
    cycle(OP_P, 0, 10'h042, 18'h0, 2'b11);
    cycle(OP_A, 0, 10'h000, 18'h0, 2'b11);
    cycle(OP_W, 0, 10'h042, 18'h00000, 2'b00);
    sleep = 1'b0; #0.5;
    check("R9 burst held across sleep", bus, 18'h000A1);
    cycle(OP_P, 0, 10'h042, 18'h0, 2'b11);
    check("R9 contents retained", bus, 18'h000A2);

    // R10: reset mid-burst releases the bus.
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    rstN = 1'b1; #1;
    tbDrv = 1'b1; tbVal = 18'h2AAAA; #0.5;
    check("R10 bus released after second reset", bus, 18'h2AAAA);
    tbDrv = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule